// File: doc/BRIEF.md
# Time-Division Island Phase Scheduler

This block lets several logical masters share one group of worker nodes by giving each of them the whole group for the length of its distribution phase. A master raises its request line when it is ready to hand out work. The scheduler grants exactly one master at a time and keeps that grant until the same master pulses its done line. The group then goes to the next requesting master in a fixed circular order, and masters that are not requesting are passed over.

A slot does not have a fixed number of cycles. It ends when the granted master reports done. The scheduler also works out how many masters the group can carry, using two unsigned inputs: the production time and the distribution time. The limit is K = floor(production / distribution) + 1. For example, a distribution time that is half the production time gives three masters. Masters whose index is at or above K are never granted. This means a system integrator can tune sharing by changing the two timing inputs, with no need to rewire request lines.

Top module: `isl_phase_sched`

## Requirements
- R1: After reset, `grant` is all zero and `capacity` reads 1. The ring pointer starts at master 0, so the first grant goes to the lowest-indexed eligible master.
- R2: One clock edge after `t_proc` and `t_dis` are applied, with `t_dis` non-zero, `capacity` equals floor(`t_proc` / `t_dis`) + 1.
- R3: When `t_dis` is zero, `capacity` becomes 1 on the next edge, whatever the value of `t_proc`.
- R4: At most one bit of `grant` is set in any cycle. Bit i of `grant` and of `req`/`done` refers to master i.
- R5: Once a master is granted, its grant bit stays set until that master's own `done` bit is sampled high. Dropping its request has no effect on the grant, and neither does another master's `done`.
- R6: The grant clears on the edge that samples the owner's `done`. On the following edge the next eligible master after the finishing one, in increasing index order wrapping from the highest index to 0, is granted.
- R7: Masters whose request is low are skipped in the ring search.
- R8: A master whose index is greater than or equal to `capacity` is never granted, even when it is requesting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t_proc | input | TW | Production phase time, unsigned |
| t_dis | input | TW | Distribution phase time, unsigned |
| req | input | N_MASTERS | Per-master request to enter the distribution phase |
| done | input | N_MASTERS | Per-master end-of-distribution pulse |
| grant | output | N_MASTERS | One-hot (or zero) exclusive grant of the worker group |
| capacity | output | TW+1 | Computed maximum number of sharing masters K |

## Verification
The bench tests the capacity formula at its edges:
- a zero distribution time, where a design that divided anyway would report garbage;
- a production time below the distribution time, where the result must be 1;
- an all-ones production time over one, which needs the extra output bit.

On the grant side, the bench raises a foreign `done` and drops the owner's request in the middle of a slot. A design that released the grant early would lose the grant there. The bench then checks that the ring wraps from the highest master back to 0 and skips idle masters. Finally, it narrows the capacity so that only masters above the limit are requesting. A design that ignored the limit would grant them, and one that cached the limit would fail to pick them up once it is raised.

// File: rtl/isl_sched_pkg.sv
package isl_sched_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } sched_st_e;
endpackage

// File: rtl/isl_cap_calc.sv
module isl_cap_calc #(
  parameter int TW = 8,
  parameter int CW = TW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] t_proc,
  input  logic [TW-1:0] t_dis,
  output logic [CW-1:0] cap
);
  localparam int PW = 2 * CW;

  logic [CW-1:0] cap_q, cap_d;
  logic          cap_en;

  always_comb begin
    if (t_dis == '0) begin
      cap_d = CW'(1);
    end else begin
      cap_d = CW'(t_proc / t_dis) + CW'(1);
    end
    cap_en = (cap_d != cap_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= CW'(1);
    end else if (cap_en) begin
      cap_q <= cap_d;
    end
  end

  assign cap = cap_q;

  // R3
  zero_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t_dis == '0) |=> (cap_q == CW'(1)));

  // R2
  cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t_dis != '0) |=>
      ((PW'(cap_q) - PW'(1)) * PW'($past(t_dis)) <= PW'($past(t_proc))) &&
      (PW'(cap_q) * PW'($past(t_dis)) > PW'($past(t_proc))));
endmodule

// File: rtl/isl_ring_pick.sv
module isl_ring_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  elig,
  input  logic [IW-1:0] start,
  output logic          vld,
  output logic [IW-1:0] idx
);
  localparam logic [IW:0] NW = (IW+1)'(N);

  logic [IW:0] pos;

  always_comb begin
    vld = 1'b0;
    idx = start;
    pos = '0;
    for (int off = 0; off < N; off++) begin
      pos = {1'b0, start} + (IW+1)'(off);
      if (pos >= NW) pos = pos - NW;
      if (!vld && elig[pos[IW-1:0]]) begin
        vld = 1'b1;
        idx = pos[IW-1:0];
      end
    end
  end

  // R7
  always_comb begin
    if (vld) begin
      pick_elig_chk: assert (elig[idx]);
    end
  end
endmodule

// File: rtl/isl_phase_sched.sv
module isl_phase_sched #(
  parameter int N_MASTERS = 4,
  parameter int TW        = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TW-1:0]        t_proc,
  input  logic [TW-1:0]        t_dis,
  input  logic [N_MASTERS-1:0] req,
  input  logic [N_MASTERS-1:0] done,
  output logic [N_MASTERS-1:0] grant,
  output logic [TW:0]          capacity
);
  import isl_sched_pkg::*;

  localparam int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;
  localparam int CW = TW + 1;
  localparam logic [IW-1:0] LAST = IW'(N_MASTERS - 1);

  sched_st_e            st_q, st_d;
  logic [N_MASTERS-1:0] grant_q, grant_d;
  logic [IW-1:0]        ptr_q, ptr_d;
  logic [IW-1:0]        owner_q, owner_d;
  logic                 upd_en;

  logic [CW-1:0]        cap_q;
  logic [N_MASTERS-1:0] elig;
  logic                 pick_vld;
  logic [IW-1:0]        pick_idx;
  logic                 owner_done;

  isl_cap_calc #(.TW(TW), .CW(CW)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .t_proc (t_proc),
    .t_dis  (t_dis),
    .cap    (cap_q)
  );

  genvar gi;
  generate
    for (gi = 0; gi < N_MASTERS; gi++) begin : g_elig
      assign elig[gi] = req[gi] && (CW'(gi) < cap_q);
    end
  endgenerate

  isl_ring_pick #(.N(N_MASTERS), .IW(IW)) u_pick (
    .elig  (elig),
    .start (ptr_q),
    .vld   (pick_vld),
    .idx   (pick_idx)
  );

  assign owner_done = done[owner_q];

  always_comb begin
    st_d    = st_q;
    grant_d = grant_q;
    ptr_d   = ptr_q;
    owner_d = owner_q;
    case (st_q)
      ST_IDLE: begin
        if (pick_vld) begin
          grant_d           = '0;
          grant_d[pick_idx] = 1'b1;
          owner_d           = pick_idx;
          st_d              = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (owner_done) begin
          grant_d = '0;
          st_d    = ST_IDLE;
          ptr_d   = (owner_q == LAST) ? '0 : owner_q + IW'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
    upd_en = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      grant_q <= '0;
      ptr_q   <= '0;
      owner_q <= '0;
    end else if (upd_en) begin
      st_q    <= st_d;
      grant_q <= grant_d;
      ptr_q   <= ptr_d;
      owner_q <= owner_d;
    end
  end

  assign grant    = grant_q;
  assign capacity = cap_q;

  // R4
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q));

  // R5
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD && !owner_done) |=> $stable(grant_q));

  // R6
  grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD && owner_done) |=> (grant_q == '0));

  // R8
  grant_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && pick_vld) |=> (CW'(owner_q) < $past(cap_q)));
endmodule

// File: tb/isl_phase_sched_tb.sv
module isl_phase_sched_tb;
  localparam int N  = 4;
  localparam int TW = 8;
  localparam int NV = 9;

  logic          clk;
  logic          rst_n;
  logic [TW-1:0] t_proc, t_dis;
  logic [N-1:0]  req, done;
  logic [N-1:0]  grant;
  logic [TW:0]   capacity;

  int n_chk;
  int n_bad;

  // capacity vectors: {t_proc, t_dis, expected K}
  localparam logic [TW-1:0] VP [NV] = '{8'd20, 8'd0,  8'd4, 8'd5, 8'd200, 8'd255, 8'd255, 8'd255, 8'd9};
  localparam logic [TW-1:0] VD [NV] = '{8'd10, 8'd5,  8'd5, 8'd5, 8'd2,   8'd1,   8'd0,   8'd255, 8'd3};
  localparam logic [TW:0]   VK [NV] = '{9'd3,  9'd1,  9'd1, 9'd2, 9'd101, 9'd256, 9'd1,   9'd2,   9'd4};

  isl_phase_sched #(.N_MASTERS(N), .TW(TW)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .t_proc   (t_proc),
    .t_dis    (t_dis),
    .req      (req),
    .done     (done),
    .grant    (grant),
    .capacity (capacity)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_grant(input string tag, input logic [N-1:0] exp);
    n_chk++;
    if (grant !== exp) begin
      n_bad++;
      $display("FAIL %s grant=%b expected=%b", tag, grant, exp);
    end
  endtask

  task automatic chk_cap(input string tag, input logic [TW:0] exp);
    n_chk++;
    if (capacity !== exp) begin
      n_bad++;
      $display("FAIL %s capacity=%0d expected=%0d", tag, capacity, exp);
    end
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    req = '0; done = '0; t_proc = '0; t_dis = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    chk_grant("R1 reset", 4'b0000);
    chk_cap("R1 reset", 9'd1);

    // R2 R3 capacity vector walk
    for (int i = 0; i < NV; i++) begin
      t_proc = VP[i];
      t_dis  = VD[i];
      tick();
      chk_cap((VD[i] == 0) ? "R3 zero dis" : "R2 formula", VK[i]);
    end

    t_proc = 8'd30; t_dis = 8'd10;
    tick();
    chk_cap("R2 k4", 9'd4);

    req = 4'b1111;
    tick();
    chk_grant("R1 first grant master0", 4'b0001);

    done = 4'b0100;
    tick();
    chk_grant("R5 foreign done", 4'b0001);
    done = 4'b0000; req = 4'b1110;
    tick();
    chk_grant("R5 owner req drop", 4'b0001);

    req = 4'b1111; done = 4'b0001;
    tick();
    chk_grant("R6 release", 4'b0000);
    done = 4'b0000;
    tick();
    chk_grant("R6 next in ring", 4'b0010);

    req = 4'b1001; done = 4'b0010;
    tick();
    done = 4'b0000;
    tick();
    chk_grant("R7 skip idle master", 4'b1000);

    done = 4'b1000;
    tick();
    done = 4'b0000;
    tick();
    chk_grant("R6 wrap to master0", 4'b0001);

    t_proc = 8'd10; t_dis = 8'd10; req = 4'b1100; done = 4'b0001;
    tick();
    chk_cap("R2 k2", 9'd2);
    done = 4'b0000;
    tick();
    chk_grant("R8 above capacity", 4'b0000);
    repeat (3) tick();
    chk_grant("R8 still blocked", 4'b0000);

    t_proc = 8'd20;
    tick();
    chk_cap("R2 k3", 9'd3);
    tick();
    chk_grant("R8 admitted after raise", 4'b0100);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule